// File: doc/BRIEF.md
# Two-Way One-Byte Processor Mailbox

The block passes single bytes between two processor buses, a host side and a parasite side, clocked from one shared clock. Each side has a chip select and a one-bit register address: address 0 is that side's status byte, and address 1 is its data byte. Each direction has its own one-byte latch. A byte written by the host is held for the parasite, and a byte written by the parasite is held for the host. The receiving side empties the latch by reading its data address.

Each side polls its status byte. The status byte reports whether a byte is waiting to be read on that side and whether that side's outgoing latch has room. Only one byte can be in flight in each direction. A sender must therefore wait until the receiver has read the byte before it writes again. A write to a full latch is dropped.

Every accepted write also produces a one-cycle strobe for that side. A separate interrupt block uses these strobes.

Top module: `duplex_mailbox`

## Requirements
- R1: After reset, neither side has data waiting and both outgoing latches are empty. A status read on either side returns 8'h40, and both write strobes are low.
- R2: The status byte is read at address 0. Bit 7 is data-available, meaning a byte is waiting for this side. Bit 6 is not-full, meaning this side's outgoing latch is empty. Bits 5..0 read as zero.
- R3: A host write to address 1 while the host not-full flag is set stores the byte. From the next cycle, parasite bit 7 is 1, host bit 6 is 0, and a parasite read of address 1 returns that byte.
- R4: A parasite write to address 1 while the parasite not-full flag is set stores the byte. From the next cycle, host bit 7 is 1, parasite bit 6 is 0, and a host read of address 1 returns that byte.
- R5: A read of address 1 by the receiving side, while its data-available flag is set, has the following effect from the next cycle: it clears that flag and sets not-full on the sending side.
- R6: A write to address 1 while the writer's not-full flag is clear is ignored. The held byte and all flags stay unchanged.
- R7: Each side has a write strobe (h_wr_pulse, p_wr_pulse). The strobe is high for exactly the one cycle after an accepted write from that side. It stays low after an ignored write.
- R8: A write to address 0 has no effect on latches, flags or strobes.
- R9: A read of address 1 while data-available is clear changes no flag.
- R10: The two directions are independent. Simultaneous writes and reads from both sides in the same cycle each take effect as if alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sel | input | 1 | Host chip select |
| h_addr | input | 1 | Host register address (0 status, 1 data) |
| h_wr | input | 1 | Host write enable |
| h_rd | input | 1 | Host read enable |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data |
| p_sel | input | 1 | Parasite chip select |
| p_addr | input | 1 | Parasite register address (0 status, 1 data) |
| p_wr | input | 1 | Parasite write enable |
| p_rd | input | 1 | Parasite read enable |
| p_wdata | input | 8 | Parasite write data |
| p_rdata | output | 8 | Parasite read data |
| h_wr_pulse | output | 1 | One-cycle strobe after an accepted host write |
| p_wr_pulse | output | 1 | One-cycle strobe after an accepted parasite write |

## Verification
A wrong full flag shows up within one cycle as the wrong status byte on both sides at once, because the same flag drives the sender's not-full bit and the receiver's data-available bit. A latch that is corrupted or overwritten after a dropped write shows up as a wrong byte at the next data read on the receiving side. A strobe that fires for a dropped write, or that lasts more than one cycle, is visible at the strobe port in the cycle after the write.

// File: rtl/duplex_mailbox.sv
module duplex_mailbox #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         h_sel,
  input  logic         h_addr,
  input  logic         h_wr,
  input  logic         h_rd,
  input  logic [W-1:0] h_wdata,
  output logic [W-1:0] h_rdata,
  input  logic         p_sel,
  input  logic         p_addr,
  input  logic         p_wr,
  input  logic         p_rd,
  input  logic [W-1:0] p_wdata,
  output logic [W-1:0] p_rdata,
  output logic         h_wr_pulse,
  output logic         p_wr_pulse
);
  localparam int PAD = W - 2;

  logic         h2p_full, p2h_full;
  logic [W-1:0] h2p_q, p2h_q;

  wire h_put  = h_sel && h_wr && h_addr && !h2p_full;
  wire p_put  = p_sel && p_wr && p_addr && !p2h_full;
  wire h_take = h_sel && h_rd && h_addr && p2h_full;
  wire p_take = p_sel && p_rd && p_addr && h2p_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h2p_full   <= 1'b0;
      p2h_full   <= 1'b0;
      h2p_q      <= '0;
      p2h_q      <= '0;
      h_wr_pulse <= 1'b0;
      p_wr_pulse <= 1'b0;
    end else begin
      h_wr_pulse <= h_put;
      p_wr_pulse <= p_put;
      if (h_put) begin
        h2p_q    <= h_wdata;
        h2p_full <= 1'b1;
      end else if (p_take) begin
        h2p_full <= 1'b0;
      end
      if (p_put) begin
        p2h_q    <= p_wdata;
        p2h_full <= 1'b1;
      end else if (h_take) begin
        p2h_full <= 1'b0;
      end
    end
  end

  assign h_rdata = h_addr ? p2h_q : {p2h_full, !h2p_full, {PAD{1'b0}}};
  assign p_rdata = p_addr ? h2p_q : {h2p_full, !p2h_full, {PAD{1'b0}}};
endmodule

// File: rtl/mailbox_checker.sv
module mailbox_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         h_sel,
  input logic         h_addr,
  input logic         h_wr,
  input logic         h_rd,
  input logic [W-1:0] h_wdata,
  input logic [W-1:0] h_rdata,
  input logic         p_sel,
  input logic         p_addr,
  input logic         p_wr,
  input logic         p_rd,
  input logic [W-1:0] p_wdata,
  input logic [W-1:0] p_rdata,
  input logic         h_wr_pulse,
  input logic         p_wr_pulse,
  input logic         h2p_full,
  input logic         p2h_full,
  input logic [W-1:0] h2p_q,
  input logic [W-1:0] p2h_q
);
  wire h_dw = h_sel && h_wr && h_addr;
  wire p_dw = p_sel && p_wr && p_addr;
  wire h_dr = h_sel && h_rd && h_addr;
  wire p_dr = p_sel && p_rd && p_addr;

  p_status_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_addr |-> h_rdata[W-3:0] == '0) and (!p_addr |-> p_rdata[W-3:0] == '0));

  p_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_dw && !h2p_full) |=> (h2p_full && h2p_q == $past(h_wdata)));

  p_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (p_dw && !p2h_full) |=> (p2h_full && p2h_q == $past(p_wdata)));

  p_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (h2p_full && p_dr) |=> !h2p_full);

  p_drain_host_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (p2h_full && h_dr) |=> !p2h_full);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (h2p_full && h_dw) |=> $stable(h2p_q));

  p_hold_par_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (p2h_full && p_dw) |=> $stable(p2h_q));

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    h_wr_pulse |-> (h2p_full && $rose(h2p_full)));

  p_pulse_par_r7: assert property (@(posedge clk) disable iff (!rst_n)
    p_wr_pulse |-> (p2h_full && $rose(p2h_full)));

  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!h2p_full && !h_dw) |=> !h2p_full);
endmodule

bind duplex_mailbox mailbox_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .h_sel(h_sel), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
  .h_wdata(h_wdata), .h_rdata(h_rdata),
  .p_sel(p_sel), .p_addr(p_addr), .p_wr(p_wr), .p_rd(p_rd),
  .p_wdata(p_wdata), .p_rdata(p_rdata),
  .h_wr_pulse(h_wr_pulse), .p_wr_pulse(p_wr_pulse),
  .h2p_full(h2p_full), .p2h_full(p2h_full),
  .h2p_q(h2p_q), .p2h_q(p2h_q)
);

// File: tb/tb_duplex_mailbox.sv
module tb_duplex_mailbox;
  logic clk = 0, rst_n = 0;
  logic h_sel = 0, h_addr = 0, h_wr = 0, h_rd = 0;
  logic p_sel = 0, p_addr = 0, p_wr = 0, p_rd = 0;
  logic [7:0] h_wdata = 0, p_wdata = 0, h_rdata, p_rdata;
  logic h_wr_pulse, p_wr_pulse;
  int errors = 0, checks = 0;
  logic m_h2p_full = 0, m_p2h_full = 0;
  logic [7:0] m_h2p = 0, m_p2h = 0;

  always #2.5 clk = ~clk;

  duplex_mailbox dut (.*);

  function automatic logic [7:0] stat(input logic da, input logic nf);
    return {da, nf, 6'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input string req,
                      input logic hs, input logic ha, input logic hw, input logic hr, input logic [7:0] hd,
                      input logic ps, input logic pa, input logic pw, input logic pr, input logic [7:0] pd);
    logic hput, pput, htake, ptake;
    @(negedge clk);
    h_sel = hs; h_addr = ha; h_wr = hw; h_rd = hr; h_wdata = hd;
    p_sel = ps; p_addr = pa; p_wr = pw; p_rd = pr; p_wdata = pd;
    #1;
    if (hs && hr) chk(req, h_rdata, ha ? m_p2h : stat(m_p2h_full, !m_h2p_full));
    if (ps && pr) chk(req, p_rdata, pa ? m_h2p : stat(m_h2p_full, !m_p2h_full));
    hput  = hs && hw && ha && !m_h2p_full;
    pput  = ps && pw && pa && !m_p2h_full;
    htake = hs && hr && ha && m_p2h_full;
    ptake = ps && pr && pa && m_h2p_full;
    if (hput) begin m_h2p = hd; m_h2p_full = 1; end else if (ptake) m_h2p_full = 0;
    if (pput) begin m_p2h = pd; m_p2h_full = 1; end else if (htake) m_p2h_full = 0;
    @(posedge clk); #1;
    chk({req, "/R7 host strobe"}, h_wr_pulse, hput);
    chk({req, "/R7 parasite strobe"}, p_wr_pulse, pput);
    h_sel = 0; p_sel = 0; h_wr = 0; p_wr = 0; h_rd = 0; p_rd = 0;
  endtask

  task automatic hstat(input string req); step(req, 1,0,0,1,0, 0,0,0,0,0); endtask
  task automatic pstat(input string req); step(req, 0,0,0,0,0, 1,0,0,1,0); endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h1A2B;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    #1;
    chk("R1 host strobe", h_wr_pulse, 0);
    chk("R1 parasite strobe", p_wr_pulse, 0);
    step("R1 status", 1,0,0,1,0, 1,0,0,1,0);
    chk("R1 host status 40", h_rdata, 8'h40);
    // R3 host to parasite
    step("R3 write", 1,1,1,0,8'hA5, 0,0,0,0,0);
    pstat("R3 parasite DA");
    chk("R3 parasite status C0", p_rdata, 8'hC0);
    hstat("R2 host NF clear");
    chk("R2 host status 00", h_rdata, 8'h00);
    // R6 ignored write
    step("R6 ignored write", 1,1,1,0,8'h22, 0,0,0,0,0);
    step("R3 data read", 0,0,0,0,0, 1,1,0,1,0);
    chk("R3 byte A5", p_rdata, 8'hA5);
    hstat("R5 sender NF set");
    chk("R5 host status 40", h_rdata, 8'h40);
    // R9 empty read
    step("R9 empty read", 0,0,0,0,0, 1,1,0,1,0);
    pstat("R9 flags unchanged");
    chk("R9 parasite status 40", p_rdata, 8'h40);
    // R8 write to status address
    step("R8 status write", 1,0,1,0,8'hFF, 1,0,1,0,8'hFF);
    step("R8 no effect", 1,0,0,1,0, 1,0,0,1,0);
    chk("R8 host status 40", h_rdata, 8'h40);
    // R4 parasite to host
    step("R4 write", 0,0,0,0,0, 1,1,1,0,8'h3C);
    hstat("R4 host DA");
    chk("R4 host status C0", h_rdata, 8'hC0);
    step("R4 data read", 1,1,0,1,0, 0,0,0,0,0);
    chk("R4 byte 3C", h_rdata, 8'h3C);
    // R10 both directions at once
    step("R10 dual write", 1,1,1,0,8'h81, 1,1,1,0,8'h7E);
    step("R10 dual status", 1,0,0,1,0, 1,0,0,1,0);
    chk("R10 host status 80", h_rdata, 8'h80);
    step("R10 dual read", 1,1,0,1,0, 1,1,0,1,0);
    chk("R10 parasite byte 81", p_rdata, 8'h81);
    chk("R10 host byte 7E", h_rdata, 8'h7E);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      step("R10 random", r[0], r[1], r[2], r[3], r[15:8],
                         r[4], r[5], r[6], r[7], r[23:16]);
    end
    hstat("R2 final"); pstat("R2 final");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule